// File: doc/BRIEF.md
# Trace Queue Overrun Guard

This block protects a debug trace event queue from losing snapshots when the queue fills. It watches the number of free queue slots and the queue write and read strobes. A three-bit mode field selects one of two policies. In message mode, overruns are allowed to happen and each one is reported with a single overrun-message pulse. In stall mode, the block requests that the traced engine pause while the queue is close to full, and releases it once enough room has returned.

A stall is never started while the engine is inside an atomic sequence of shared-memory accesses. A breakpoint request always wins over a stall and sends the engine to HALT, which is left only on a debug-resume strobe. Rewriting the mode field acts without waiting for the normal threshold compare. After an overrun, snapshot storing is suspended until the queue has drained completely. Other traffic sources can still fill the queue, so an overrun can also occur in stall mode.

Top module: `trq_ovr_guard`

## Requirements
- R1: A write of `cfg_wdata` = 3'b011 selects stall mode. Every other value (000, 001, 010, 100–111) selects message mode. From the cycle after the write, `cfg_rdata` reads 3'b011 or 3'b000 to match, and reserved values behave exactly like 000, so no stall is ever requested.
- R2: In stall mode with the engine running and no atomic sequence, `free_cnt` <= STALL_ON (7) raises `stall_req` on the next cycle.
- R3: While stalled, `free_cnt` >= STALL_OFF (8) drops `stall_req` on the next cycle. With fewer free slots, the stall holds.
- R4: While `atomic_busy` is high, no stall is started. A pending stall takes effect on the cycle after `atomic_busy` falls.
- R5: A breakpoint request in a cycle where a stall would start, or while stalled, raises `halt_req` on the next cycle with `stall_req` low. `stall_req` and `halt_req` are never high together.
- R6: `halt_req` stays high until `dbg_resume` is asserted. It is low on the cycle after the resume.
- R7: Writing 3'b011 while `free_cnt` < 5 raises `stall_req` on the next cycle, even though the mode was message mode before the write.
- R8: Writing any value that is not 3'b011 while stalled drops `stall_req` on the next cycle, whatever the free count.
- R9: A write strobe with no simultaneous read while `free_cnt` = 0 and storing is enabled gives a one-cycle `ovr_msg` pulse on the next cycle and clears `store_en` in that same cycle. A simultaneous read prevents the overrun.
- R10: While `store_en` is low, further writes into a full queue produce no `ovr_msg`.
- R11: `store_en` rises on the cycle after `free_cnt` equals DEPTH (16), and not before.
- R12: An overrun is still reported while the engine is stalled in stall mode.
- R13: After synchronous reset, the mode reads 000, `stall_req`, `halt_req` and `ovr_msg` are low, and `store_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Mode field write strobe |
| cfg_wdata | input | 3 | Mode field write value |
| cfg_rdata | output | 3 | Legalised mode field readback |
| free_cnt | input | $clog2(DEPTH+1) | Free slots currently in the trace queue |
| q_wr | input | 1 | Queue write attempt |
| q_rd | input | 1 | Queue read in the same cycle |
| atomic_busy | input | 1 | Engine is inside an atomic shared-memory sequence |
| bkpt_req | input | 1 | Breakpoint request |
| dbg_resume | input | 1 | Leave HALT |
| stall_req | output | 1 | Stall request to the traced engine |
| halt_req | output | 1 | Engine held in HALT |
| ovr_msg | output | 1 | One-cycle overrun message pulse |
| store_en | output | 1 | Snapshot storing enabled |

## Verification
The bench builds the block with its defaults: DEPTH 16, a stall-on level of 7, a stall-off level of 8 and a mode-write level of 5. It sweeps every free count from 0 to 16 for stall entry, for stall release and for the immediate reaction to a mode write. This puts both sides of each threshold in reach, together with the empty and full boundaries. It also writes all eight mode codes to confirm that the reserved codes are legalised. Directed sequences cover the atomic hold-off, breakpoint priority, overrun suspension with its drain-to-empty recovery, and overruns that occur during a stall.

// File: rtl/trq_pkg.sv
package trq_pkg;

    typedef enum logic [2:0] {
        MODE_MSG   = 3'b000,
        MODE_STALL = 3'b011
    } trq_mode_e;

    typedef enum logic [1:0] {
        ENG_RUN   = 2'd0,
        ENG_STALL = 2'd1,
        ENG_HALT  = 2'd2
    } trq_eng_e;

    // Only the stall code is kept; anything else collapses to message mode
    function automatic trq_mode_e trq_legalize(input logic [2:0] raw);
        return (raw == 3'b011) ? MODE_STALL : MODE_MSG;
    endfunction

endpackage

// File: rtl/trq_mode_reg.sv
module trq_mode_reg
    import trq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wr,
    input  logic [2:0] cfg_wdata,
    output trq_mode_e mode_q,
    output logic      wr_stall,
    output logic      wr_other
);

    typedef struct packed {
        trq_mode_e mode;
    } mode_st_t;

    mode_st_t st_d, st_q;
    trq_mode_e wr_mode;

    always_comb begin
        wr_mode  = trq_legalize(cfg_wdata);
        wr_stall = cfg_wr && (wr_mode == MODE_STALL);
        wr_other = cfg_wr && (wr_mode != MODE_STALL);
        st_d     = st_q;
        if (cfg_wr) begin
            st_d.mode = wr_mode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_MSG;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q = st_q.mode;

endmodule

// File: rtl/trq_stall_fsm.sv
module trq_stall_fsm
    import trq_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int STALL_ON  = 7,
    parameter int STALL_OFF = 8,
    parameter int WR_LIM    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  trq_mode_e        mode_q,
    input  logic             wr_stall,
    input  logic             wr_other,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic             atomic_busy,
    input  logic             bkpt_req,
    input  logic             dbg_resume,
    output trq_eng_e         eng_q
);

    localparam logic [CNT_W-1:0] ON_LVL  = CNT_W'(STALL_ON);
    localparam logic [CNT_W-1:0] OFF_LVL = CNT_W'(STALL_OFF);
    localparam logic [CNT_W-1:0] WR_LVL  = CNT_W'(WR_LIM);

    typedef struct packed {
        trq_eng_e eng;
    } fsm_st_t;

    fsm_st_t st_d, st_q;
    logic    in_stall_mode;
    logic    want_enter;
    logic    want_leave;

    always_comb begin
        // Mode register contents count only if not being overwritten now
        in_stall_mode = (mode_q == MODE_STALL) && !wr_other;
        want_enter    = !atomic_busy &&
                        ((in_stall_mode && (free_cnt <= ON_LVL)) ||
                         (wr_stall && (free_cnt < WR_LVL)));
        want_leave    = !in_stall_mode || (free_cnt >= OFF_LVL);
        st_d          = st_q;
        unique case (st_q.eng)
            ENG_RUN: begin
                if (bkpt_req) begin
                    st_d.eng = ENG_HALT;
                end else if (want_enter) begin
                    st_d.eng = ENG_STALL;
                end
            end
            ENG_STALL: begin
                if (bkpt_req) begin
                    st_d.eng = ENG_HALT;
                end else if (want_leave) begin
                    st_d.eng = ENG_RUN;
                end
            end
            ENG_HALT: begin
                if (dbg_resume) begin
                    st_d.eng = ENG_RUN;
                end
            end
            default: st_d.eng = ENG_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.eng <= ENG_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign eng_q = st_q.eng;

endmodule

// File: rtl/trq_ovr_track.sv
module trq_ovr_track #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic             q_wr,
    input  logic             q_rd,
    output logic             ovr_msg,
    output logic             store_en
);

    localparam logic [CNT_W-1:0] EMPTY_LVL = CNT_W'(DEPTH);

    typedef struct packed {
        logic store;
        logic msg;
    } ovr_st_t;

    ovr_st_t st_d, st_q;
    logic    overflow;

    always_comb begin
        overflow = q_wr && !q_rd && (free_cnt == '0);
        st_d     = st_q;
        st_d.msg = 1'b0;
        if (st_q.store) begin
            if (overflow) begin
                st_d.msg   = 1'b1;
                st_d.store = 1'b0;
            end
        end else if (free_cnt == EMPTY_LVL) begin
            st_d.store = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.store <= 1'b1;
            st_q.msg   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovr_msg  = st_q.msg;
    assign store_en = st_q.store;

endmodule

// File: rtl/trq_ovr_guard.sv
module trq_ovr_guard
    import trq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int STALL_ON  = 7,
    parameter int STALL_OFF = 8,
    parameter int WR_LIM    = 5,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_wdata,
    output logic [2:0]       cfg_rdata,
    input  logic [CNT_W-1:0] free_cnt,
    input  logic             q_wr,
    input  logic             q_rd,
    input  logic             atomic_busy,
    input  logic             bkpt_req,
    input  logic             dbg_resume,
    output logic             stall_req,
    output logic             halt_req,
    output logic             ovr_msg,
    output logic             store_en
);

    trq_mode_e mode_q;
    trq_eng_e  eng_q;
    logic      wr_stall;
    logic      wr_other;

    trq_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .mode_q   (mode_q),
        .wr_stall (wr_stall),
        .wr_other (wr_other)
    );

    trq_stall_fsm #(
        .CNT_W    (CNT_W),
        .STALL_ON (STALL_ON),
        .STALL_OFF(STALL_OFF),
        .WR_LIM   (WR_LIM)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_q     (mode_q),
        .wr_stall   (wr_stall),
        .wr_other   (wr_other),
        .free_cnt   (free_cnt),
        .atomic_busy(atomic_busy),
        .bkpt_req   (bkpt_req),
        .dbg_resume (dbg_resume),
        .eng_q      (eng_q)
    );

    trq_ovr_track #(
        .DEPTH(DEPTH),
        .CNT_W(CNT_W)
    ) u_ovr (
        .clk     (clk),
        .rst     (rst),
        .free_cnt(free_cnt),
        .q_wr    (q_wr),
        .q_rd    (q_rd),
        .ovr_msg (ovr_msg),
        .store_en(store_en)
    );

    assign cfg_rdata = mode_q;
    assign stall_req = (eng_q == ENG_STALL);
    assign halt_req  = (eng_q == ENG_HALT);

endmodule

// File: rtl/trq_ovr_guard_chk.sv
module trq_ovr_guard_chk #(
    parameter int DEPTH     = 16,
    parameter int STALL_OFF = 8,
    parameter int CNT_W     = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic [2:0]       cfg_wdata,
    input logic [2:0]       cfg_rdata,
    input logic [CNT_W-1:0] free_cnt,
    input logic             q_wr,
    input logic             q_rd,
    input logic             atomic_busy,
    input logic             bkpt_req,
    input logic             dbg_resume,
    input logic             stall_req,
    input logic             halt_req,
    input logic             ovr_msg,
    input logic             store_en
);

    localparam logic [CNT_W-1:0] OFF_LVL   = CNT_W'(STALL_OFF);
    localparam logic [CNT_W-1:0] EMPTY_LVL = CNT_W'(DEPTH);

    AST_RDATA_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata == 3'b000) || (cfg_rdata == 3'b011)); // R1
    AST_RESERVED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_wdata != 3'b011) |=> (cfg_rdata == 3'b000)); // R1
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (stall_req && !bkpt_req && !cfg_wr && free_cnt >= OFF_LVL) |=> !stall_req); // R3
    AST_ATOMIC_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (!stall_req && atomic_busy) |=> !stall_req); // R4
    AST_HALT_STALL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(stall_req && halt_req)); // R5
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !dbg_resume) |=> halt_req); // R6
    AST_OVR_DETECT: assert property (@(posedge clk) disable iff (rst)
        (store_en && q_wr && !q_rd && free_cnt == '0) |=> (ovr_msg && !store_en)); // R9
    AST_OVR_PULSE: assert property (@(posedge clk) disable iff (rst)
        ovr_msg |=> !ovr_msg); // R9
    AST_ONE_MSG: assert property (@(posedge clk) disable iff (rst)
        !store_en |=> !ovr_msg); // R10
    AST_STORE_RESUME: assert property (@(posedge clk) disable iff (rst)
        (!store_en && free_cnt == EMPTY_LVL) |=> store_en); // R11

endmodule

bind trq_ovr_guard trq_ovr_guard_chk #(
    .DEPTH    (DEPTH),
    .STALL_OFF(STALL_OFF),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .free_cnt   (free_cnt),
    .q_wr       (q_wr),
    .q_rd       (q_rd),
    .atomic_busy(atomic_busy),
    .bkpt_req   (bkpt_req),
    .dbg_resume (dbg_resume),
    .stall_req  (stall_req),
    .halt_req   (halt_req),
    .ovr_msg    (ovr_msg),
    .store_en   (store_en)
);

// File: tb/trq_ovr_guard_tb.sv
module trq_ovr_guard_tb_top;

    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_wr;
    logic [2:0]       cfg_wdata;
    logic [2:0]       cfg_rdata;
    logic [CNT_W-1:0] free_cnt;
    logic             q_wr, q_rd, atomic_busy, bkpt_req, dbg_resume;
    logic             stall_req, halt_req, ovr_msg, store_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    trq_ovr_guard dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .free_cnt(free_cnt), .q_wr(q_wr), .q_rd(q_rd),
        .atomic_busy(atomic_busy), .bkpt_req(bkpt_req), .dbg_resume(dbg_resume),
        .stall_req(stall_req), .halt_req(halt_req), .ovr_msg(ovr_msg),
        .store_en(store_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_mode(input logic [2:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        step();
        cfg_wr = 1'b0;
    endtask

    // Back to a running engine with an empty queue and storing enabled
    task automatic settle();
        cfg_wr = 1'b0; q_wr = 1'b0; q_rd = 1'b0; bkpt_req = 1'b0;
        atomic_busy = 1'b0; free_cnt = CNT_W'(DEPTH); dbg_resume = 1'b1;
        step();
        dbg_resume = 1'b0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = 3'b000; free_cnt = CNT_W'(DEPTH);
        q_wr = 1'b0; q_rd = 1'b0; atomic_busy = 1'b0; bkpt_req = 1'b0; dbg_resume = 1'b0;
        step(); step();
        // R13 reset state
        chk("R13 rdata", cfg_rdata, 0);
        chk("R13 stall", stall_req, 0);
        chk("R13 halt", halt_req, 0);
        chk("R13 ovr", ovr_msg, 0);
        chk("R13 store", store_en, 1);
        rst = 1'b0;
        step();

        // R1 all codes: readback and behaviour with a full queue
        for (int v = 0; v < 8; v++) begin
            settle();
            wr_mode(3'(v));
            chk("R1 readback", cfg_rdata, (v == 3) ? 3 : 0);
            free_cnt = '0;
            step();
            chk("R1 reserved no stall", stall_req, (v == 3) ? 1 : 0);
        end

        // R2 stall entry sweep
        settle();
        wr_mode(3'b011);
        for (int f = 0; f <= DEPTH; f++) begin
            settle();
            free_cnt = CNT_W'(f);
            step();
            chk("R2 entry", stall_req, (f <= 7) ? 1 : 0);
        end

        // R3 release sweep from the stall state
        for (int f = 0; f <= DEPTH; f++) begin
            settle();
            free_cnt = '0;
            step();
            free_cnt = CNT_W'(f);
            step();
            chk("R3 release", stall_req, (f < 8) ? 1 : 0);
        end

        // R4 atomic hold-off
        settle();
        free_cnt = 5'd3; atomic_busy = 1'b1;
        step();
        chk("R4 blocked", stall_req, 0);
        step(); step();
        chk("R4 still blocked", stall_req, 0);
        atomic_busy = 1'b0;
        step();
        chk("R4 after atomic", stall_req, 1);

        // R5 breakpoint together with a stall start
        settle();
        free_cnt = 5'd3; bkpt_req = 1'b1;
        step();
        bkpt_req = 1'b0;
        chk("R5 halt", halt_req, 1);
        chk("R5 no stall", stall_req, 0);
        // R5 breakpoint while stalled
        settle();
        free_cnt = '0;
        step();
        bkpt_req = 1'b1;
        step();
        bkpt_req = 1'b0;
        chk("R5 halt from stall", halt_req, 1);
        chk("R5 stall dropped", stall_req, 0);
        // R6 halt persists without resume, even with an empty queue
        free_cnt = CNT_W'(DEPTH);
        step(); step(); step();
        chk("R6 held", halt_req, 1);
        dbg_resume = 1'b1;
        step();
        dbg_resume = 1'b0;
        chk("R6 resumed", halt_req, 0);

        // R7 mode write reacts at once below the write level
        for (int f = 0; f <= DEPTH; f++) begin
            settle();
            wr_mode(3'b000);
            free_cnt = CNT_W'(f);
            cfg_wr = 1'b1; cfg_wdata = 3'b011;
            step();
            cfg_wr = 1'b0;
            chk("R7 immediate", stall_req, (f < 5) ? 1 : 0);
            step();
            chk("R7 then normal", stall_req, (f <= 7) ? 1 : 0);
        end

        // R8 leaving stall mode releases at once
        settle();
        wr_mode(3'b011);
        free_cnt = '0;
        step();
        chk("R8 stalled", stall_req, 1);
        cfg_wr = 1'b1; cfg_wdata = 3'b110;
        step();
        cfg_wr = 1'b0;
        chk("R8 dropped", stall_req, 0);
        step();
        chk("R8 stays low", stall_req, 0);

        // R9 overrun pulse and suspension, message mode
        settle();
        wr_mode(3'b000);
        free_cnt = '0; q_wr = 1'b1; q_rd = 1'b1;
        step();
        chk("R9 read saves slot", ovr_msg, 0);
        chk("R9 store kept", store_en, 1);
        q_rd = 1'b0;
        step();
        q_wr = 1'b0;
        chk("R9 pulse", ovr_msg, 1);
        chk("R9 suspended", store_en, 0);
        step();
        chk("R9 one cycle", ovr_msg, 0);
        // R10 no second message while suspended
        q_wr = 1'b1;
        step(); step();
        q_wr = 1'b0;
        chk("R10 no repeat", ovr_msg, 0);
        // R11 drain sweep
        for (int f = 0; f < DEPTH; f++) begin
            free_cnt = CNT_W'(f);
            step();
            chk("R11 not yet", store_en, 0);
        end
        free_cnt = CNT_W'(DEPTH);
        step();
        chk("R11 resumed", store_en, 1);

        // R12 overrun while stalled
        settle();
        wr_mode(3'b011);
        free_cnt = '0;
        step();
        q_wr = 1'b1;
        step();
        q_wr = 1'b0;
        chk("R12 msg in stall", ovr_msg, 1);
        chk("R12 still stalled", stall_req, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule